// File: doc/BRIEF.md
# Pipeline Interlock and Operand Forwarding Controller

This block decides, cycle by cycle, how a five-stage in-order integer pipeline (fetch, decode/register read, execute/address generation, memory access, write-back) copes with dependencies between instructions in flight. It looks at the register fields and control flags held in the decode, execute, memory and write-back pipeline registers. From them it computes operand source selects for the execute-stage ALU inputs, a late source select for store data in the memory stage, source selects for the branch comparator in decode, a stall that freezes PC and the fetch/decode register while a bubble enters execute, and a flush that turns a wrongly fetched instruction into a no-op after a taken branch.

The controller is purely combinational. The surrounding datapath owns every pipeline register and applies the outputs at the next clock edge. The register file writes in the first half of a cycle and reads in the second, so a value in write-back reaches a decode-stage reader without help. A parameter adds a structural interlock for a single shared instruction/data memory port. The clock and reset inputs serve only the embedded property checks.

Top module: `hazard_ctl`

## Requirements
- R1: With no instruction writing any register and no branch or memory access in flight, every output is 0.
- R2: An execute-stage source register written by a non-load instruction in memory stage selects code 01 (EX/MEM result) on `ex_a_sel`/`ex_b_sel`, with no stall for a back-to-back ALU dependency.
- R3: A source written only by the instruction in write-back selects code 10 (MEM/WB value). When both memory stage and write-back match, code 01 wins. Code 00 means register-file value.
- R4: Register 0 never causes forwarding, store-data forwarding, branch forwarding or a stall.
- R5: A load in execute whose destination is read in decode as an ALU operand, as a load base or as a store base raises `stall` for exactly one cycle. The consumer then takes code 10 in execute.
- R6: A load feeding only the data operand (rs2) of the following store causes no stall. `st_data_fwd` is 1 when a store in memory stage has its data register written by the write-back instruction.
- R7: A branch in decode stalls while an instruction in execute writes one of its operands. It also stalls while a load in memory stage does, so an ALU producer costs one stall cycle and a load costs two. A non-load producer in memory stage sets `br_a_fwd`/`br_b_fwd`; a write-back producer needs neither.
- R8: `flush` is 1 exactly when a branch in decode is taken and `stall` is 0.
- R9: With `UNIFIED_MEM` set, a load or store in memory stage raises `stall`. With it clear, memory-stage accesses never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| id_rs1 | input | REG_AW | Decode-stage first source register |
| id_rs2 | input | REG_AW | Decode-stage second source register (store data for stores) |
| id_uses_rs1 | input | 1 | Decode instruction reads rs1 |
| id_uses_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Comparator outcome for the branch in decode |
| ex_rs1 | input | REG_AW | Execute-stage first source register |
| ex_rs2 | input | REG_AW | Execute-stage second source register |
| ex_rd | input | REG_AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rs2 | input | REG_AW | Memory-stage store data register |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_is_load | input | 1 | Memory instruction is a load |
| mem_is_store | input | 1 | Memory instruction is a store |
| wb_rd | input | REG_AW | Write-back destination register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| ex_a_sel | output | 2 | ALU operand A source: 00 RF, 01 EX/MEM, 10 MEM/WB |
| ex_b_sel | output | 2 | ALU operand B / store data source, same codes |
| st_data_fwd | output | 1 | Store data in memory stage taken from MEM/WB |
| br_a_fwd | output | 1 | Branch comparator A taken from EX/MEM |
| br_b_fwd | output | 1 | Branch comparator B taken from EX/MEM |
| stall | output | 1 | Hold PC and IF/ID, insert bubble into execute |
| flush | output | 1 | Replace IF/ID with a no-op |

## Verification
The bench runs producer/consumer pairs through a shadow pipeline that obeys the stall output. It counts the stall cycles each pair costs and records the selects as the consumer passes each stage. One target is a load feeding store data versus store base: a design that treats both alike either stalls when it need not or reads stale data. Another is the two-cycle load-to-branch interlock, where a design that releases after one cycle would compare a value that does not yet exist. The bench also drives double matches to catch inverted EX/MEM versus MEM/WB priority, register 0 destinations to catch spurious forwarding, and a taken branch under stall to catch a flush that discards the branch's own successor too early.

// File: rtl/hazard_pkg.sv
// Shared encodings for the interlock and forwarding controller.
// Assumes operand multiplexers in the datapath decode these codes directly.
package hazard_pkg;
    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } src_sel_e;
endpackage

// File: rtl/hz_operand_fwd.sv
// Source select for one execute-stage operand.
// Assumes a load result is not valid in EX/MEM, so loads forward only from MEM/WB.
module hz_operand_fwd #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        sel
);
    import hazard_pkg::*;

    logic mem_hit;
    logic wb_hit;
    src_sel_e sel_e;

    // Match against the younger stage first so it takes priority.
    always_comb begin
        mem_hit = mem_wen && !mem_is_load && (mem_rd != '0) && (mem_rd == src_reg);
        wb_hit  = wb_wen && (wb_rd != '0) && (wb_rd == src_reg);
        if (mem_hit)     sel_e = SRC_EXMEM;
        else if (wb_hit) sel_e = SRC_MEMWB;
        else             sel_e = SRC_RF;
        sel = sel_e;
    end
endmodule

// File: rtl/hz_interlock.sv
// Stall, flush and branch-comparator forwarding for the decode stage.
// Assumes branches resolve in decode and the register file writes before it reads.
module hz_interlock #(
    parameter int REG_AW      = 5,
    parameter bit UNIFIED_MEM = 1'b0
) (
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_uses_rs1,
    input  logic              id_uses_rs2,
    input  logic              id_is_store,
    input  logic              id_is_branch,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic              mem_is_store,
    output logic [1:0]        br_fwd,
    output logic              stall,
    output logic              flush
);
    localparam int NSRC = 2;

    logic [REG_AW-1:0] src   [NSRC];
    logic [NSRC-1:0]   used;
    logic [NSRC-1:0]   ex_match;
    logic [NSRC-1:0]   mem_match;
    logic              load_use;
    logic              br_wait_ex;
    logic              br_wait_load;
    logic              port_clash;

    assign src[0] = id_rs1;
    assign src[1] = id_rs2;
    assign used   = {id_uses_rs2, id_uses_rs1};

    // Per-source comparison against the execute and memory destinations.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign ex_match[i]  = used[i] && ex_wen && (ex_rd != '0) && (ex_rd == src[i]);
        assign mem_match[i] = used[i] && mem_wen && (mem_rd != '0) && (mem_rd == src[i]);
        assign br_fwd[i]    = id_is_branch && mem_match[i] && !mem_is_load;
    end

    // Structural interlock exists only in the shared-port variant.
    if (UNIFIED_MEM) begin : g_shared_port
        assign port_clash = mem_is_load || mem_is_store;
    end else begin : g_split_port
        assign port_clash = 1'b0;
    end

    // Combine hazard causes; store data (rs2) is served late in memory stage.
    always_comb begin
        load_use     = ex_is_load && (ex_match[0] || (ex_match[1] && !id_is_store));
        br_wait_ex   = id_is_branch && (|ex_match);
        br_wait_load = id_is_branch && mem_is_load && (|mem_match);
        stall        = load_use || br_wait_ex || br_wait_load || port_clash;
        flush        = id_is_branch && id_br_taken && !stall;
    end
endmodule

// File: rtl/hazard_ctl.sv
// Interlock and forwarding controller for a five-stage in-order pipeline.
// Purely combinational; clk/rst_n clock only the embedded property checks.
// Assumes the datapath applies stall/flush to its own pipeline registers.
module hazard_ctl #(
    parameter int REG_AW      = 5,
    parameter bit UNIFIED_MEM = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_uses_rs1,
    input  logic              id_uses_rs2,
    input  logic              id_is_store,
    input  logic              id_is_branch,
    input  logic              id_br_taken,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rs2,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        ex_a_sel,
    output logic [1:0]        ex_b_sel,
    output logic              st_data_fwd,
    output logic              br_a_fwd,
    output logic              br_b_fwd,
    output logic              stall,
    output logic              flush
);
    localparam int NOPND = 2;

    logic [REG_AW-1:0] ex_src [NOPND];
    logic [1:0]        ex_sel [NOPND];
    logic [1:0]        br_fwd;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    // One select unit per execute operand.
    for (genvar i = 0; i < NOPND; i++) begin : g_opnd
        hz_operand_fwd #(.REG_AW(REG_AW)) u_fwd (
            .src_reg     (ex_src[i]),
            .mem_rd      (mem_rd),
            .mem_wen     (mem_wen),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_wen      (wb_wen),
            .sel         (ex_sel[i])
        );
    end

    assign ex_a_sel = ex_sel[0];
    assign ex_b_sel = ex_sel[1];

    hz_interlock #(.REG_AW(REG_AW), .UNIFIED_MEM(UNIFIED_MEM)) u_lock (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_uses_rs1  (id_uses_rs1),
        .id_uses_rs2  (id_uses_rs2),
        .id_is_store  (id_is_store),
        .id_is_branch (id_is_branch),
        .id_br_taken  (id_br_taken),
        .ex_rd        (ex_rd),
        .ex_wen       (ex_wen),
        .ex_is_load   (ex_is_load),
        .mem_rd       (mem_rd),
        .mem_wen      (mem_wen),
        .mem_is_load  (mem_is_load),
        .mem_is_store (mem_is_store),
        .br_fwd       (br_fwd),
        .stall        (stall),
        .flush        (flush)
    );

    assign br_a_fwd = br_fwd[0];
    assign br_b_fwd = br_fwd[1];

    // Late store-data path: value leaving write-back feeds the store in memory stage.
    always_comb begin
        st_data_fwd = mem_is_store && wb_wen && (wb_rd != '0) && (wb_rd == mem_rs2);
    end

    // R4: a zero source never picks a forwarded value.
    p_no_r0_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (ex_a_sel == 2'b00));

    // R3: the memory-stage ALU result beats write-back on a double match.
    p_exmem_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && !mem_is_load && wb_wen && (mem_rd == wb_rd) && (ex_rs2 == mem_rd) && (ex_rs2 != '0))
        |-> (ex_b_sel == 2'b01));

    // R5: a load feeding a decode-stage address or ALU operand holds decode.
    p_load_use_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_wen && (ex_rd != '0) && id_uses_rs1 && (id_rs1 == ex_rd)) |-> stall);

    // R6: store-data forwarding only ever targets a store.
    p_stdata_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_fwd |-> mem_is_store);

    // R7: a branch waits while its operand is still being loaded.
    p_branch_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && mem_is_load && mem_wen && (mem_rd != '0) && id_uses_rs2 && (id_rs2 == mem_rd))
        |-> stall);

    // R8: flush and stall never coincide, and flush needs a branch.
    p_flush_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall && id_is_branch));

    // R9: a shared memory port blocks fetch during any data access.
    p_port_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (UNIFIED_MEM && (mem_is_load || mem_is_store)) |-> stall);
endmodule

// File: tb/hazard_ctl_bench.sv
// Directed bench: a shadow pipeline moves instruction pairs under the DUT's stall.
module hazard_ctl_bench;
    typedef struct packed {
        logic [3:0] tag;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       wen;
        logic       load;
        logic       store;
        logic       branch;
        logic       u1;
        logic       u2;
    } instr_t;

    localparam instr_t NOP = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    instr_t id_s, ex_s, mem_s, wb_s;
    logic   taken;

    logic [1:0] a_sel, b_sel, ua_sel, ub_sel;
    logic sdf, bra, brb, stall, flush;
    logic usdf, ubra, ubrb, ustall, uflush;

    int n_checks = 0;
    int n_fail = 0;

    initial begin
        id_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP; taken = 1'b0;
    end

    hazard_ctl u_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_s.rs1), .id_rs2(id_s.rs2), .id_uses_rs1(id_s.u1), .id_uses_rs2(id_s.u2),
        .id_is_store(id_s.store), .id_is_branch(id_s.branch), .id_br_taken(taken),
        .ex_rs1(ex_s.rs1), .ex_rs2(ex_s.rs2), .ex_rd(ex_s.rd), .ex_wen(ex_s.wen), .ex_is_load(ex_s.load),
        .mem_rs2(mem_s.rs2), .mem_rd(mem_s.rd), .mem_wen(mem_s.wen), .mem_is_load(mem_s.load),
        .mem_is_store(mem_s.store), .wb_rd(wb_s.rd), .wb_wen(wb_s.wen),
        .ex_a_sel(a_sel), .ex_b_sel(b_sel), .st_data_fwd(sdf), .br_a_fwd(bra), .br_b_fwd(brb),
        .stall(stall), .flush(flush)
    );

    hazard_ctl #(.UNIFIED_MEM(1'b1)) u_hazard_ctl_unified (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_s.rs1), .id_rs2(id_s.rs2), .id_uses_rs1(id_s.u1), .id_uses_rs2(id_s.u2),
        .id_is_store(id_s.store), .id_is_branch(id_s.branch), .id_br_taken(taken),
        .ex_rs1(ex_s.rs1), .ex_rs2(ex_s.rs2), .ex_rd(ex_s.rd), .ex_wen(ex_s.wen), .ex_is_load(ex_s.load),
        .mem_rs2(mem_s.rs2), .mem_rd(mem_s.rd), .mem_wen(mem_s.wen), .mem_is_load(mem_s.load),
        .mem_is_store(mem_s.store), .wb_rd(wb_s.rd), .wb_wen(wb_s.wen),
        .ex_a_sel(ua_sel), .ex_b_sel(ub_sel), .st_data_fwd(usdf), .br_a_fwd(ubra), .br_b_fwd(ubrb),
        .stall(ustall), .flush(uflush)
    );

    function automatic instr_t mk_alu(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        instr_t t = NOP;
        t.rd = rd; t.rs1 = rs1; t.rs2 = rs2; t.wen = 1'b1; t.u1 = 1'b1; t.u2 = 1'b1;
        return t;
    endfunction

    function automatic instr_t mk_load(input logic [4:0] rd, input logic [4:0] base);
        instr_t t = NOP;
        t.rd = rd; t.rs1 = base; t.wen = 1'b1; t.load = 1'b1; t.u1 = 1'b1;
        return t;
    endfunction

    function automatic instr_t mk_store(input logic [4:0] base, input logic [4:0] data);
        instr_t t = NOP;
        t.rs1 = base; t.rs2 = data; t.store = 1'b1; t.u1 = 1'b1; t.u2 = 1'b1;
        return t;
    endfunction

    function automatic instr_t mk_branch(input logic [4:0] rs1, input logic [4:0] rs2);
        instr_t t = NOP;
        t.rs1 = rs1; t.rs2 = rs2; t.branch = 1'b1; t.u1 = 1'b1; t.u2 = 1'b1;
        return t;
    endfunction

    // Compare one observed value against its expectation.
    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive a pair through the shadow pipeline and record what the consumer saw.
    task automatic run_pair(input instr_t p, input instr_t c, output int stalls,
                            output logic [1:0] as, output logic [1:0] bs, output logic sd,
                            output logic ba, output logic bb);
        logic fed = 1'b0;
        stalls = 0; as = 2'b11; bs = 2'b11; sd = 1'b0; ba = 1'b0; bb = 1'b0;
        p.tag = 4'd1; c.tag = 4'd2;
        @(negedge clk);
        id_s = p; ex_s = NOP; mem_s = NOP; wb_s = NOP; taken = 1'b0;
        for (int cyc = 0; cyc < 10; cyc++) begin
            @(negedge clk);
            if (id_s.tag == 4'd2) begin
                if (stall) stalls++;
                else begin ba = bra; bb = brb; end
            end
            if (ex_s.tag == 4'd2) begin as = a_sel; bs = b_sel; end
            if (mem_s.tag == 4'd2) sd = sdf;
            wb_s = mem_s;
            mem_s = ex_s;
            if (stall) ex_s = NOP;
            else begin
                ex_s = id_s;
                id_s = fed ? NOP : c;
                fed = 1'b1;
            end
        end
    endtask

    // Load stage registers directly for a single-cycle observation.
    task automatic set_stages(input instr_t i, input instr_t e, input instr_t m, input instr_t w, input logic tk);
        @(negedge clk);
        id_s = i; ex_s = e; mem_s = m; wb_s = w; taken = tk;
        #1;
    endtask

    task automatic t_idle;
        set_stages(NOP, NOP, NOP, NOP, 1'b0);
        check("R1", "idle outputs", int'({a_sel, b_sel, sdf, bra, brb, stall, flush}), 0);
        check("R1", "idle unified stall", int'(ustall), 0);
    endtask

    task automatic t_alu_alu;
        int s; logic [1:0] as, bs; logic sd, ba, bb;
        run_pair(mk_alu(5'd1, 5'd2, 5'd3), mk_alu(5'd4, 5'd1, 5'd5), s, as, bs, sd, ba, bb);
        check("R2", "alu->alu stalls", s, 0);
        check("R2", "alu->alu a_sel", int'(as), 1);
        check("R2", "alu->alu b_sel", int'(bs), 0);
        run_pair(mk_alu(5'd7, 5'd2, 5'd3), mk_store(5'd8, 5'd7), s, as, bs, sd, ba, bb);
        check("R2", "alu->store data b_sel", int'(bs), 1);
    endtask

    task automatic t_priority;
        set_stages(NOP, mk_alu(5'd9, 5'd6, 5'd6), mk_alu(5'd6, 5'd1, 5'd1), mk_alu(5'd6, 5'd2, 5'd2), 1'b0);
        check("R3", "double match a_sel", int'(a_sel), 1);
        set_stages(NOP, mk_alu(5'd9, 5'd6, 5'd3), NOP, mk_alu(5'd6, 5'd2, 5'd2), 1'b0);
        check("R3", "wb only a_sel", int'(a_sel), 2);
        check("R3", "no match b_sel", int'(b_sel), 0);
    endtask

    task automatic t_reg0;
        set_stages(mk_alu(5'd3, 5'd0, 5'd0), mk_load(5'd0, 5'd2), mk_alu(5'd0, 5'd1, 5'd1),
                   mk_alu(5'd0, 5'd1, 5'd1), 1'b0);
        check("R4", "r0 load no stall", int'(stall), 0);
        set_stages(mk_branch(5'd0, 5'd0), mk_alu(5'd4, 5'd0, 5'd0), mk_store(5'd1, 5'd0),
                   mk_alu(5'd0, 5'd1, 5'd1), 1'b0);
        check("R4", "r0 selects", int'({a_sel, b_sel, sdf, bra, brb, stall}), 0);
    endtask

    task automatic t_load_use;
        int s; logic [1:0] as, bs; logic sd, ba, bb;
        run_pair(mk_load(5'd1, 5'd2), mk_alu(5'd4, 5'd1, 5'd5), s, as, bs, sd, ba, bb);
        check("R5", "load->alu stalls", s, 1);
        check("R5", "load->alu a_sel", int'(as), 2);
        run_pair(mk_load(5'd1, 5'd2), mk_store(5'd1, 5'd6), s, as, bs, sd, ba, bb);
        check("R5", "load->store base stalls", s, 1);
        check("R5", "load->store base a_sel", int'(as), 2);
        run_pair(mk_load(5'd1, 5'd2), mk_load(5'd3, 5'd1), s, as, bs, sd, ba, bb);
        check("R5", "load->load base stalls", s, 1);
    endtask

    task automatic t_load_store_data;
        int s; logic [1:0] as, bs; logic sd, ba, bb;
        run_pair(mk_load(5'd1, 5'd2), mk_store(5'd3, 5'd1), s, as, bs, sd, ba, bb);
        check("R6", "load->store data stalls", s, 0);
        check("R6", "store data late fwd", int'(sd), 1);
        check("R6", "store data no EX fwd", int'(bs), 0);
    endtask

    task automatic t_branch;
        int s; logic [1:0] as, bs; logic sd, ba, bb;
        run_pair(mk_alu(5'd1, 5'd2, 5'd3), mk_branch(5'd1, 5'd4), s, as, bs, sd, ba, bb);
        check("R7", "alu->branch stalls", s, 1);
        check("R7", "alu->branch a fwd", int'(ba), 1);
        run_pair(mk_load(5'd1, 5'd2), mk_branch(5'd4, 5'd1), s, as, bs, sd, ba, bb);
        check("R7", "load->branch stalls", s, 2);
        check("R7", "load->branch b fwd", int'(bb), 0);
        set_stages(mk_branch(5'd5, 5'd6), NOP, NOP, mk_alu(5'd5, 5'd1, 5'd1), 1'b0);
        check("R7", "wb->branch no stall/fwd", int'({stall, bra, brb}), 0);
    endtask

    task automatic t_flush;
        set_stages(mk_branch(5'd5, 5'd6), NOP, NOP, NOP, 1'b1);
        check("R8", "taken flush", int'(flush), 1);
        set_stages(mk_branch(5'd5, 5'd6), NOP, NOP, NOP, 1'b0);
        check("R8", "not taken flush", int'(flush), 0);
        set_stages(mk_branch(5'd5, 5'd6), mk_alu(5'd5, 5'd1, 5'd1), NOP, NOP, 1'b1);
        check("R8", "taken under stall flush", int'(flush), 0);
    endtask

    task automatic t_unified;
        set_stages(NOP, NOP, mk_load(5'd1, 5'd2), NOP, 1'b0);
        check("R9", "split mode load no stall", int'(stall), 0);
        check("R9", "unified load stall", int'(ustall), 1);
        set_stages(NOP, NOP, mk_store(5'd1, 5'd2), NOP, 1'b0);
        check("R9", "unified store stall", int'(ustall), 1);
        set_stages(NOP, NOP, mk_alu(5'd1, 5'd2, 5'd3), NOP, 1'b0);
        check("R9", "unified alu no stall", int'(ustall), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_idle;
        t_alu_alu;
        t_priority;
        t_reg0;
        t_load_use;
        t_load_store_data;
        t_branch;
        t_flush;
        t_unified;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule